// File: doc/BRIEF.md
# Flow Control Calendar Transmitter

This block feeds the flow-control part of outgoing link control words. User logic presents a wide vector with one XON/XOFF bit per calendar entry (1 = XON, 0 = XOFF). Each time the transmit framer asks for a control word, the block returns the next 16 calendar entries as a 16-bit field, plus a flag that marks the first group of a calendar pass. The framer places the field in control-word bits 55..40 and the flag in bit 56. The framer also builds the rest of the word, the CRC and the lane handling.

A request pulse `fc_req` is answered one clock later by `fc_valid`, together with the field and the flag. The calendar length is set by the parameter `CAL_LEN`. It must be a multiple of 16 and no more than 256, and it sets the group at which the walk wraps back to entry 0. The status vector is sampled in the request cycle, one whole group at a time, so a returned group is always self-consistent.

Top module: `fc_cal_tx`

## Requirements
- R1: After reset `fc_valid`, `fc_bits` and `fc_cal_start` are all 0, and the first request after reset returns group 0 with `fc_cal_start` = 1.
- R2: `fc_valid` is 1 in exactly the cycle after each cycle in which `fc_req` is 1, and 0 otherwise.
- R3: In a response for group g, `fc_bits[15-k]` equals status entry 16*g+k for k = 0..15. So bit 15, which maps to word bit 55, carries the lowest entry of the group.
- R4: Each request advances the group index by one. Cycles without a request leave the index unchanged.
- R5: After group CAL_LEN/16-1 has been returned, the next request returns group 0 again.
- R6: `fc_cal_start` is 1 in a response exactly when that response carries group 0.
- R7: The field reflects the status vector as it was in the request cycle. A later change of the vector does not alter an answer already given.
- R8: In cycles without a request, `fc_bits` and `fc_cal_start` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User-side clock; the status vector is synchronous to it |
| rst_n | input | 1 | Synchronous reset, active low |
| xon_vec | input | N_MAX | Per-entry status, 1 = XON, 0 = XOFF |
| fc_req | input | 1 | Framer asks for the next control-word fields |
| fc_valid | output | 1 | Response strobe, one cycle after the request |
| fc_bits | output | GRP | Flow-control field for word bits 55..40 |
| fc_cal_start | output | 1 | Calendar-start flag for word bit 56 |

## Verification
Two events can coincide: the calendar wrap, where a request both returns the last group and moves the index back to 0, and a change of the status vector in the same cycle as a request. The bench issues back-to-back requests across the wrap while it changes the vector pattern on every cycle. It checks that the group after the wrap carries the start flag and the bits of the vector value driven in that request cycle, not the value driven before or after it. It also holds a request over a vector change to confirm that the returned field stays frozen.

// File: rtl/fc_cal_tx.sv
module fc_cal_tx #(
  parameter int N_MAX   = 256,
  parameter int GRP     = 16,
  parameter int CAL_LEN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MAX-1:0] xon_vec,
  input  logic             fc_req,
  output logic             fc_valid,
  output logic [GRP-1:0]   fc_bits,
  output logic             fc_cal_start
);
  localparam int NGRP_MAX = N_MAX / GRP;
  localparam int NGRP     = CAL_LEN / GRP;
  localparam int IW       = (NGRP_MAX > 1) ? $clog2(NGRP_MAX) : 1;
  localparam logic [IW-1:0] LAST = IW'(NGRP - 1);

  logic [IW-1:0]  grp_q;
  logic [GRP-1:0] slice;
  logic [GRP-1:0] rev;

  assign slice = xon_vec[grp_q*GRP +: GRP];

  for (genvar k = 0; k < GRP; k++) begin : g_rev
    assign rev[GRP-1-k] = slice[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q        <= '0;
      fc_valid     <= 1'b0;
      fc_bits      <= '0;
      fc_cal_start <= 1'b0;
    end else begin
      fc_valid <= fc_req;
      if (fc_req) begin
        fc_bits      <= rev;
        fc_cal_start <= (grp_q == '0);
        grp_q        <= (grp_q == LAST) ? '0 : grp_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fc_cal_tx_chk.sv
module fc_cal_tx_chk #(
  parameter int N_MAX   = 256,
  parameter int GRP     = 16,
  parameter int CAL_LEN = 256
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fc_req,
  input logic           fc_valid,
  input logic [GRP-1:0] fc_bits,
  input logic           fc_cal_start
);
  localparam int NGRP = CAL_LEN / GRP;
  int resp_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) resp_cnt <= 0;
    else if (fc_valid) resp_cnt <= (resp_cnt == NGRP - 1) ? 0 : resp_cnt + 1;
  end

  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    fc_req |=> fc_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_req |=> !fc_valid);
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_req |=> ($stable(fc_bits) && $stable(fc_cal_start)));
  a_r6_start_on_group0: assert property (@(posedge clk) disable iff (!rst_n)
    fc_valid |-> (fc_cal_start == (resp_cnt == 0)));
endmodule

bind fc_cal_tx fc_cal_tx_chk #(.N_MAX(N_MAX), .GRP(GRP), .CAL_LEN(CAL_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .fc_req(fc_req), .fc_valid(fc_valid),
  .fc_bits(fc_bits), .fc_cal_start(fc_cal_start)
);

// File: tb/fc_cal_tx_test.sv
module fc_cal_tx_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [255:0] xon;
  logic         req;
  logic         valid;
  logic [15:0]  bits;
  logic         cstart;

  always #4 clk = ~clk;

  fc_cal_tx uut (
    .clk(clk), .rst_n(rst_n), .xon_vec(xon), .fc_req(req),
    .fc_valid(valid), .fc_bits(bits), .fc_cal_start(cstart)
  );

  int vecs = 0;
  int bad = 0;
  int g = 0;
  logic        exp_v;
  logic [15:0] exp_b;
  logic        exp_s;
  bit          done = 0;

  // {req, seed}
  localparam logic [16:0] TAB [0:23] = '{
    17'h1_a5c3, 17'h1_0001, 17'h0_ffff, 17'h1_8000, 17'h1_1234,
    17'h0_0000, 17'h0_5555, 17'h1_ffff, 17'h1_0f0f, 17'h1_c001,
    17'h1_7e7e, 17'h1_0000, 17'h1_beef, 17'h0_dead, 17'h1_4321,
    17'h1_aaaa, 17'h1_5555, 17'h1_0ff0, 17'h1_f00f, 17'h1_1111,
    17'h1_2222, 17'h0_3333, 17'h1_9999, 17'h1_6006
  };

  function automatic logic [255:0] mk(input logic [15:0] s);
    logic [255:0] v;
    for (int i = 0; i < 16; i++) v[i*16 +: 16] = s ^ 16'(i * 3855);
    return v;
  endfunction

  function automatic logic [15:0] expf(input logic [255:0] v, input int gi);
    logic [15:0] f;
    for (int k = 0; k < 16; k++) f[15-k] = v[gi*16 + k];
    return f;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, then check at the next negedge
  task automatic step(input logic r, input logic [15:0] s, input string tag);
    req = r;
    xon = mk(s);
    if (r) begin
      exp_v = 1'b1;
      exp_b = expf(xon, g);
      exp_s = (g == 0);
      g = (g + 1) % 16;
    end else begin
      exp_v = 1'b0;
    end
    @(negedge clk);
    check({tag, " R2 valid"}, 32'(valid), 32'(exp_v));
    check({tag, " R3 bits"}, 32'(bits), 32'(exp_b));
    check({tag, " R6 start"}, 32'(cstart), 32'(exp_s));
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; xon = '0;
    exp_v = 1'b0; exp_b = '0; exp_s = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(valid), 0);
    check("R1 reset bits", 32'(bits), 0);
    check("R1 reset start", 32'(cstart), 0);
    rst_n = 1'b1;

    // table walk: gaps (R4, R8), more than 16 requests so the index wraps (R5)
    for (int i = 0; i < 24; i++) step(TAB[i][16], TAB[i][15:0], "R4 R5 R8 table");

    // R7: request with one pattern, then change the vector with no request
    step(1'b1, 16'h3c3c, "R7 sample");
    step(1'b0, 16'hc3c3, "R7 frozen");
    step(1'b0, 16'h0000, "R7 frozen2");

    // R5: back-to-back across the wrap, vector changing every cycle
    for (int i = 0; i < 20; i++) step(1'b1, 16'(i * 40503 + 7), "R5 wrap");

    // R1: mid-run reset, first request returns group 0 with start
    req = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset valid", 32'(valid), 0);
    check("R1 reset start", 32'(cstart), 0);
    rst_n = 1'b1;
    g = 0; exp_b = '0; exp_s = 1'b0;
    step(1'b1, 16'h8421, "R1 first");
    step(1'b1, 16'h1248, "R1 second");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      vecs++;
      bad++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule